// File: doc/BRIEF.md
# Per-CPU Soft Interrupt Pending Register

This block keeps the interrupt pending word of one processor. The lower half of the 32-bit word records hardware interrupt levels, which the interrupt router sets and clears one level at a time. The upper half holds software-raised interrupts. Software raises them by writing a set word and drops them by writing a clear word on a small word-addressed register port.

The software bits are returned to the router as a 16-bit level vector. This vector is the upper half of the pending word moved down by 16 places, with level 0 always zero. The router ORs it into the processor's level lines. A clear write has one quirk: a value with bit 14 set also clears bit 31, which is the level-15 soft bit.

Every write to the set or clear word raises a one-cycle update pulse. The pulse tells the router to recompute its level outputs. All outputs are registers.

Top module: `soft_irq_pend`

## Requirements
- R1: While reset is high, and on the first edge after it, the pending word is zero. The soft level vector, update pulse and read data are all zero.
- R2: A write to word address 2 ORs the data into the pending word, limited to the soft mask 0xFFFE0000 (bits 17 to 31). All other bits of the data are dropped.
- R3: A write to word address 1 clears soft bits. First, bit 31 is added to the value when its bit 14 is set. The value is then limited to the soft mask, and those bits are cleared in the pending word.
- R4: A read of word address 0 returns the pending word as it was before that edge. The data appears on the read output one cycle later. The read output is zero in every other cycle.
- R5: A write to any word address other than 1 or 2 leaves the pending word unchanged.
- R6: The soft level vector equals (pending AND 0xFFFE0000) >> 16. It is updated on the same edge as the pending word, and its bit 0 is always zero.
- R7: A hardware strobe with a nonzero level L sets bit L of the pending word when the on flag is 1 and clears it when the flag is 0. A strobe with level 0 has no effect.
- R8: The update pulse is high for exactly the one cycle after a write to word address 1 or 2, and is low otherwise.
- R9: A hardware strobe and a register write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| hw_stb | input | 1 | Hardware level change strobe |
| hw_on | input | 1 | 1 raises, 0 lowers the level |
| hw_lvl | input | 4 | Hardware interrupt level |
| soft_lvl | output | 16 | Soft interrupt levels for the router |
| upd_pulse | output | 1 | One-cycle recompute request |

## Verification
The hardest case to reach is a clear write whose bit 14 is set while bit 31 is clear, landing when level-15 soft is pending. Ordinary random data seldom hits this pairing, and it is the only case that shows the quirk. The stimulus therefore biases random clear data so that bit 14 is often set and bit 31 is often clear. It also adds directed sequences that set the top soft bit and then clear it through bit 14 alone, and that mix hardware strobes into the same cycle as bus writes.

// File: rtl/soft_irq_pkg.sv
package soft_irq_pkg;
  typedef enum logic [1:0] {
    WA_STATUS = 2'd0,
    WA_CLEAR  = 2'd1,
    WA_SET    = 2'd2
  } word_addr_e;
endpackage

// File: rtl/soft_irq_decode.sv
module soft_irq_decode #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] set_bits,
  output logic [DATA_W-1:0] clr_bits,
  output logic              upd_req
);
  import soft_irq_pkg::*;
  localparam int HALF    = DATA_W / 2;
  localparam int ALIAS_B = HALF - 2;
  localparam logic [DATA_W-1:0] SOFT_MASK = {{(HALF-1){1'b1}}, {(HALF+1){1'b0}}};

  logic hit_set, hit_clr;
  logic [DATA_W-1:0] clr_raw;

  always_comb begin
    hit_set = wr_en && (addr == ADDR_W'(WA_SET));
    hit_clr = wr_en && (addr == ADDR_W'(WA_CLEAR));
    clr_raw = wdata;
    if (wdata[ALIAS_B]) clr_raw[DATA_W-1] = 1'b1;
    set_bits = hit_set ? (wdata & SOFT_MASK) : '0;
    clr_bits = hit_clr ? (clr_raw & SOFT_MASK) : '0;
    upd_req  = hit_set || hit_clr;
  end
endmodule

// File: rtl/soft_irq_store.sv
module soft_irq_store #(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_bits,
  input  logic [DATA_W-1:0] clr_bits,
  input  logic              hw_stb,
  input  logic              hw_on,
  input  logic [LVL_W-1:0]  hw_lvl,
  output logic [DATA_W-1:0] pend_q,
  output logic [DATA_W-1:0] pend_d
);
  localparam int NLVL = 1 << LVL_W;

  logic [DATA_W-1:0] hw_set, hw_clr;

  for (genvar g = 0; g < DATA_W; g++) begin : g_hw
    if (g > 0 && g < NLVL) begin : g_lvl
      assign hw_set[g] = hw_stb && hw_on  && (hw_lvl == LVL_W'(g));
      assign hw_clr[g] = hw_stb && !hw_on && (hw_lvl == LVL_W'(g));
    end else begin : g_none
      assign hw_set[g] = 1'b0;
      assign hw_clr[g] = 1'b0;
    end
  end

  always_comb pend_d = ((pend_q | set_bits | hw_set) & ~(clr_bits | hw_clr));

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end
endmodule

// File: rtl/soft_irq_pend.sv
module soft_irq_pend #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              hw_stb,
  input  logic              hw_on,
  input  logic [LVL_W-1:0]  hw_lvl,
  output logic [DATA_W/2-1:0] soft_lvl,
  output logic              upd_pulse
);
  import soft_irq_pkg::*;
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] set_bits, clr_bits, pend_q, pend_d;
  logic              upd_req;

  soft_irq_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .set_bits(set_bits), .clr_bits(clr_bits), .upd_req(upd_req)
  );

  soft_irq_store #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_store (
    .clk(clk), .rst(rst), .set_bits(set_bits), .clr_bits(clr_bits),
    .hw_stb(hw_stb), .hw_on(hw_on), .hw_lvl(hw_lvl),
    .pend_q(pend_q), .pend_d(pend_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      soft_lvl  <= '0;
      upd_pulse <= 1'b0;
    end else begin
      reg_rdata <= (reg_rd && reg_addr == ADDR_W'(WA_STATUS)) ? pend_q : '0;
      soft_lvl  <= {pend_d[DATA_W-1:HALF+1], 1'b0};
      upd_pulse <= upd_req;
    end
  end
endmodule

// File: rtl/soft_irq_pend_chk.sv
module soft_irq_pend_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W/2-1:0] soft_lvl,
  input logic              upd_pulse
);
  localparam int HALF = DATA_W / 2;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (soft_lvl == '0 && !upd_pulse && reg_rdata == '0)); // R1
  AST_SET_TOP: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(2) && reg_wdata[DATA_W-1]) |=> soft_lvl[HALF-1]); // R2
  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[HALF-2]) |=> !soft_lvl[HALF-1]); // R3
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_addr == ADDR_W'(0)) |=> reg_rdata == '0); // R4
  AST_LVL0_ZERO: assert property (@(posedge clk) disable iff (rst)
    !soft_lvl[0]); // R6
  AST_UPD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> $past(reg_wr && (reg_addr == ADDR_W'(1) || reg_addr == ADDR_W'(2)))); // R8
  AST_UPD_ONE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_addr == ADDR_W'(1) || reg_addr == ADDR_W'(2))) |=> upd_pulse); // R8
endmodule

bind soft_irq_pend soft_irq_pend_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .soft_lvl(soft_lvl),
  .upd_pulse(upd_pulse)
);

// File: tb/sim_soft_irq_pend.sv
`timescale 1ns/1ps
module sim_soft_irq_pend;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        hw_stb = 1'b0, hw_on = 1'b0;
  logic [3:0]  hw_lvl = '0;
  logic [15:0] soft_lvl;
  logic        upd_pulse;

  int n_run = 0, n_fail = 0;
  logic [31:0] model = '0;
  bit done = 0;

  always #10 clk = ~clk;

  soft_irq_pend u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_stb(hw_stb), .hw_on(hw_on),
    .hw_lvl(hw_lvl), .soft_lvl(soft_lvl), .upd_pulse(upd_pulse)
  );

  localparam logic [31:0] SMASK = 32'hFFFE_0000;

  function automatic logic [31:0] f_next(logic [31:0] p, logic wr, logic [3:0] a,
      logic [31:0] d, logic hs, logic ho, logic [3:0] hl);
    logic [31:0] c;
    c = d;
    if (d[14]) c[31] = 1'b1;
    if (wr && a == 4'd2) p = p | (d & SMASK);
    if (wr && a == 4'd1) p = p & ~(c & SMASK);
    if (hs && hl != 0) p[hl] = ho;
    return p;
  endfunction

  function automatic logic [15:0] f_soft(logic [31:0] p);
    return 16'((p & SMASK) >> 16);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check after the edge
  task automatic step(string req, logic wr, logic rd, logic [3:0] a, logic [31:0] d,
      logic hs, logic ho, logic [3:0] hl);
    logic [31:0] exp_rd;
    logic exp_up;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    hw_stb = hs; hw_on = ho; hw_lvl = hl;
    exp_rd = (rd && a == 4'd0) ? model : 32'h0;
    exp_up = wr && (a == 4'd1 || a == 4'd2);
    model  = f_next(model, wr, a, d, hs, ho, hl);
    @(posedge clk); #1;
    chk({req, " soft"}, {16'h0, soft_lvl}, {16'h0, f_soft(model)});
    chk({req, " upd"}, {31'h0, upd_pulse}, {31'h0, exp_up});
    chk({req, " rdata"}, reg_rdata, exp_rd);
  endtask

  task automatic rd_back(string req);
    step(req, 0, 0, 4'd0, 0, 0, 0, 0);
    step(req, 0, 1, 4'd0, 0, 0, 0, 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 soft", {16'h0, soft_lvl}, 32'h0);
    chk("R1 upd", {31'h0, upd_pulse}, 32'h0);
    chk("R1 rdata", reg_rdata, 32'h0);
    @(negedge clk); rst = 1'b0;
    rd_back("R1 readback");

    // R2 set limited to mask
    step("R2", 1, 0, 4'd2, 32'hFFFF_FFFF, 0, 0, 0);
    rd_back("R2 readback");
    // R3 quirk: bit 14 alone clears bit 31
    step("R3 alias", 1, 0, 4'd1, 32'h0000_4000, 0, 0, 0);
    rd_back("R3 readback");
    step("R3 plain", 1, 0, 4'd1, 32'h0002_0000, 0, 0, 0);
    // R5 other words ignored
    step("R5 w0", 1, 0, 4'd0, 32'h0000_0000, 0, 0, 0);
    step("R5 w3", 1, 0, 4'd3, 32'hFFFF_FFFF, 0, 0, 0);
    step("R5 w15", 1, 0, 4'd15, 32'h0, 0, 0, 0);
    rd_back("R5 readback");
    // R4 reads of other words are zero
    step("R4 other", 0, 1, 4'd2, 0, 0, 0, 0);
    // R7 hw levels, level 0 ignored
    step("R7 on5", 0, 0, 0, 0, 1, 1, 4'd5);
    step("R7 on0", 0, 0, 0, 0, 1, 1, 4'd0);
    rd_back("R7 readback");
    step("R7 off5", 0, 0, 0, 0, 1, 0, 4'd5);
    rd_back("R7 readback2");
    // R9 simultaneous hw and write
    step("R9", 1, 0, 4'd2, 32'h8004_0000, 1, 1, 4'd15);
    rd_back("R9 readback");
    step("R9 clr", 1, 0, 4'd1, 32'h0004_4000, 1, 0, 4'd15);
    rd_back("R9 readback2");
    // R6 R8 random traffic, clear data biased towards bit14 without bit31
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      logic [3:0] a;
      d = $urandom;
      a = 4'($urandom_range(0, 4));
      if (a == 4'd1 && ($urandom_range(0, 1) == 1)) begin
        d[14] = 1'b1; d[31] = 1'b0;
      end
      step("R6 R8 rand", 1'($urandom), 1'($urandom), a, d,
           1'($urandom), 1'($urandom), 4'($urandom));
    end
    // R1 reset mid-run
    @(negedge clk); rst = 1'b1; model = '0;
    reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    chk("R1 midreset soft", {16'h0, soft_lvl}, 32'h0);
    chk("R1 midreset upd", {31'h0, upd_pulse}, 32'h0);
    @(negedge clk); rst = 1'b0; reg_wr = 1'b0;
    rd_back("R1 after");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule